// File: doc/BRIEF.md
# FPGA Configuration Command Sequencer

This block is the command side of a controller that loads a bitstream into a target FPGA over its configuration SPI port. A single start request walks the target through the complete programming flow. The block turns on configuration access and reads back a four-byte result to confirm it. It then switches the target into programming mode, streams the bitstream as fixed 16-byte frames and turns configuration access off again. After a wait of about 1.5 ms it sends the release command that hands the device back to user operation.

The block does not shift bits itself. It hands one byte at a time to a byte-level SPI master and holds chip select for the length of each transaction. Before every transaction it asks an external status poller to wait until the target is no longer busy. Before the read-back it also waits for the target's ready flag. Bitstream bytes come in on a valid/ready stream. The caller supplies the payload length in bytes and a flag that marks a partial-reconfiguration request. The block reports progress through `busy`, a one-cycle `done` pulse, a held error code and a programming-mode flag. Software can combine that flag with a zero status to decide that the target is operating.

Top module: `cfgseq`

## Requirements
- R1: The first transaction of an accepted start is the single byte 0x0B, alone under chip select.
- R2: The second transaction is the byte 0x01 followed by four dummy 0x00 bytes. The four bytes returned during the dummies are ORed. A nonzero result ends the run with error code 3, and no further transaction is issued.
- R3: The third transaction is the two bytes 0xAE, 0x01. `prog_mode` rises once that transaction completes and falls once the release transaction completes.
- R4: The block issues exactly payload_len/16 frame transactions. Each one is 0xEE followed by the next 16 stream bytes in arrival order. A stalled stream only delays the frame.
- R5: Every transaction follows a status poll that reported success. `poll_want_ready` is high only during the poll that precedes the read-back transaction.
- R6: A failed poll ends the run at once, with no further transaction. Poll result 1 (timeout) gives error code 4, and results 2 or 3 (bus error) give error code 5.
- R7: After the last frame, the block sends 0x0C alone and then pauses for DELAY_CYC = CLK_HZ*3/2000 cycles. It then polls and sends 0x23 alone. A run ends with `prog_mode` low and error code 0.
- R8: A payload length that is not a multiple of 16 gives error code 1, and no poll or transaction takes place.
- R9: A partial-reconfiguration request gives error code 2 and issues no poll or transaction. This check takes precedence over the length check.
- R10: `done` pulses for one cycle when a run ends, and `busy` is low in that cycle. The error code keeps its value until the next accepted start, which clears it. A run that aborts leaves `prog_mode` unchanged.
- R11: A start asserted while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (taken only when idle) |
| partial_req | input | 1 | Run is a partial reconfiguration (refused) |
| payload_len | input | LEN_W | Bitstream payload length in bytes |
| frame_data | input | 8 | Bitstream stream byte |
| frame_valid | input | 1 | Stream byte valid |
| frame_ready | output | 1 | Stream byte consumed this cycle |
| spi_cs | output | 1 | Chip select, high for the span of one transaction |
| spi_req | output | 1 | Byte exchange request to the SPI master |
| spi_wdata | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Byte exchanged this cycle |
| spi_rdata | input | 8 | Byte received, valid with spi_ack |
| poll_req | output | 1 | Ask the status poller to wait for a non-busy target |
| poll_want_ready | output | 1 | Poller must also see the ready flag |
| poll_done | input | 1 | Poller finished this cycle |
| poll_result | input | 2 | 0 ok, 1 timeout, 2 or 3 bus error |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| err_code | output | 3 | First failure cause of the last run |
| prog_mode | output | 1 | Target is in programming mode |

## Verification
The hardest situations to reach from the ports are aborts at a chosen point deep in the flow, such as a poll that fails just before the third frame. A bench poller counts poll requests and injects a timeout or a bus error at a configured index, sweeping that index across every poll of a run. The read-back failure is reached by having the SPI responder return a nonzero byte. The release pause is measured as the cycles between the disable byte and the next poll request.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam logic [7:0] OP_CFG_ON   = 8'h0B;
    localparam logic [7:0] OP_CFG_OFF  = 8'h0C;
    localparam logic [7:0] OP_FETCH    = 8'h01;
    localparam logic [7:0] OP_MODE     = 8'hAE;
    localparam logic [7:0] OP_MODE_ARG = 8'h01;
    localparam logic [7:0] OP_FRAME    = 8'hEE;
    localparam logic [7:0] OP_HANDOFF  = 8'h23;
    localparam logic [7:0] OP_DUMMY    = 8'h00;

    localparam int FRAME_BYTES = 16;
    localparam int FETCH_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_POLL, ST_XFER, ST_GAP, ST_WAIT
    } state_t;

    typedef enum logic [2:0] {
        SP_CFG_ON, SP_FETCH, SP_MODE, SP_FRAME, SP_CFG_OFF, SP_HANDOFF
    } step_t;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_BAD_LEN = 3'd1,
        E_UNSUPP  = 3'd2,
        E_ENABLE  = 3'd3,
        E_TIMEOUT = 3'd4,
        E_BUS     = 3'd5
    } err_t;

    function automatic logic [4:0] step_bytes(step_t s);
        case (s)
            SP_FETCH: step_bytes = 5'(1 + FETCH_BYTES);
            SP_MODE:  step_bytes = 5'd2;
            SP_FRAME: step_bytes = 5'(1 + FRAME_BYTES);
            default:  step_bytes = 5'd1;
        endcase
    endfunction

    function automatic logic [7:0] step_byte(step_t s, logic [4:0] i);
        case (s)
            SP_CFG_ON:  step_byte = OP_CFG_ON;
            SP_FETCH:   step_byte = (i == 5'd0) ? OP_FETCH : OP_DUMMY;
            SP_MODE:    step_byte = (i == 5'd0) ? OP_MODE : OP_MODE_ARG;
            SP_FRAME:   step_byte = OP_FRAME;
            SP_CFG_OFF: step_byte = OP_CFG_OFF;
            default:    step_byte = OP_HANDOFF;
        endcase
    endfunction

    function automatic step_t step_next(step_t s, logic more);
        case (s)
            SP_CFG_ON:  step_next = SP_FETCH;
            SP_FETCH:   step_next = SP_MODE;
            SP_MODE,
            SP_FRAME:   step_next = more ? SP_FRAME : SP_CFG_OFF;
            SP_CFG_OFF: step_next = SP_HANDOFF;
            default:    step_next = SP_HANDOFF;
        endcase
    endfunction

    function automatic err_t poll_to_err(logic [1:0] r);
        poll_to_err = (r == 2'd1) ? E_TIMEOUT : E_BUS;
    endfunction

endpackage

// File: rtl/cfgseq_delay.sv
module cfgseq_delay #(
    parameter int CYCLES = 150000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(CYCLES - 1));

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(CYCLES)));

endmodule

// File: rtl/cfgseq_framer.sv
module cfgseq_framer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len,
    input  logic             load,
    input  logic             dec,
    input  logic             in_frame,
    output logic             len_ok,
    output logic             more
);
    localparam int FW = LEN_W - 4;

    logic [FW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= len[LEN_W-1:4];
        end else if (dec) begin
            left <= left - 1'b1;
        end
    end

    assign len_ok = (len[3:0] == 4'd0);
    assign more   = in_frame ? (left > FW'(1)) : (left != '0);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> (left != '0));

endmodule

// File: rtl/cfgseq_readback.sv
module cfgseq_readback (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       capture,
    input  logic [7:0] data,
    output logic       nonzero
);
    logic [7:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (capture) begin
            acc <= acc | data;
        end
    end

    assign nonzero = (acc != 8'd0);

endmodule

// File: rtl/cfgseq.sv
module cfgseq
    import cfgseq_pkg::*;
#(
    parameter int CLK_HZ = 100000000,
    parameter int LEN_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             partial_req,
    input  logic [LEN_W-1:0] payload_len,
    input  logic [7:0]       frame_data,
    input  logic             frame_valid,
    output logic             frame_ready,
    output logic             spi_cs,
    output logic             spi_req,
    output logic [7:0]       spi_wdata,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rdata,
    output logic             poll_req,
    output logic             poll_want_ready,
    input  logic             poll_done,
    input  logic [1:0]       poll_result,
    output logic             busy,
    output logic             done,
    output logic [2:0]       err_code,
    output logic             prog_mode
);
    localparam int RAW_DLY   = (CLK_HZ / 1000) * 3 / 2;
    localparam int DELAY_CYC = (RAW_DLY < 1) ? 1 : RAW_DLY;

    state_t     state;
    step_t      step;
    logic [4:0] idx;
    err_t       err;

    logic payload, last_byte, fire, accept;
    logic len_ok, more, rb_nonzero, expired;

    assign payload   = (step == SP_FRAME) && (idx != 5'd0);
    assign last_byte = (idx == step_bytes(step) - 5'd1);
    assign spi_cs    = (state == ST_XFER);
    assign spi_req   = spi_cs && (!payload || frame_valid);
    assign spi_wdata = payload ? frame_data : step_byte(step, idx);
    assign fire      = spi_req && spi_ack;
    assign frame_ready = fire && payload;

    assign poll_req        = (state == ST_POLL);
    assign poll_want_ready = poll_req && (step == SP_FETCH);
    assign busy            = (state != ST_IDLE);
    assign err_code        = err;
    assign accept          = (state == ST_IDLE) && start;

    cfgseq_framer #(.LEN_W(LEN_W)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .len      (payload_len),
        .load     (accept && !partial_req && len_ok),
        .dec      ((state == ST_GAP) && (step == SP_FRAME)),
        .in_frame (step == SP_FRAME),
        .len_ok   (len_ok),
        .more     (more)
    );

    cfgseq_readback u_readback (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (fire && (step == SP_FETCH) && (idx != 5'd0)),
        .data    (spi_rdata),
        .nonzero (rb_nonzero)
    );

    cfgseq_delay #(.CYCLES(DELAY_CYC)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= SP_CFG_ON;
            idx       <= '0;
            err       <= E_NONE;
            done      <= 1'b0;
            prog_mode <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (partial_req) begin
                            err  <= E_UNSUPP;
                            done <= 1'b1;
                        end else if (!len_ok) begin
                            err  <= E_BAD_LEN;
                            done <= 1'b1;
                        end else begin
                            err   <= E_NONE;
                            step  <= SP_CFG_ON;
                            state <= ST_POLL;
                        end
                    end
                end
                ST_POLL: begin
                    if (poll_done) begin
                        if (poll_result != 2'd0) begin
                            err   <= poll_to_err(poll_result);
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx   <= '0;
                            state <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (fire) begin
                        if (last_byte) begin
                            state <= ST_GAP;
                            if (step == SP_MODE)    prog_mode <= 1'b1;
                            if (step == SP_HANDOFF) prog_mode <= 1'b0;
                        end else begin
                            idx <= idx + 5'd1;
                        end
                    end
                end
                ST_GAP: begin
                    case (step)
                        SP_FETCH: begin
                            if (rb_nonzero) begin
                                err   <= E_ENABLE;
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                step  <= SP_MODE;
                                state <= ST_POLL;
                            end
                        end
                        SP_CFG_OFF: begin
                            step  <= SP_HANDOFF;
                            state <= ST_WAIT;
                        end
                        SP_HANDOFF: begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                        default: begin
                            step  <= step_next(step, more);
                            state <= ST_POLL;
                        end
                    endcase
                end
                ST_WAIT: begin
                    if (expired) state <= ST_POLL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r5_cs_after_poll: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs) |-> ($past(poll_req) && $past(poll_done)));

    a_r6_abort_on_fail: assert property (@(posedge clk) disable iff (rst)
        (poll_req && poll_done && (poll_result != 2'd0)) |=> (!spi_cs && !busy));

    a_r4_take_needs_valid: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> frame_valid);

    a_r3_mode_after_txn: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_mode) |-> ($past(spi_cs) && ($past(spi_wdata) == OP_MODE_ARG)));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_err_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(err_code));

endmodule

// File: tb/cfgseq_tb.sv
module cfgseq_tb;
    localparam int CLK_HZ = 20000;
    localparam int LEN_W  = 12;
    localparam int DLY    = CLK_HZ * 3 / 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, partial_req = 1'b0;
    logic [LEN_W-1:0] payload_len = '0;
    logic [7:0] frame_data;
    logic frame_valid = 1'b1, frame_ready;
    logic spi_cs, spi_req, spi_ack = 1'b0;
    logic [7:0] spi_wdata, spi_rdata = 8'h00;
    logic poll_req, poll_want_ready, poll_done = 1'b0;
    logic [1:0] poll_result = 2'd0;
    logic busy, done, prog_mode;
    logic [2:0] err_code;

    int nchk = 0, nerr = 0, cyc = 0, sidx = 0;
    int fail_at = -1;
    logic [1:0] fail_kind = 2'd0;
    logic [7:0] rd_val = 8'h00;
    bit stall = 1'b0, prev_cs = 1'b0, in_poll = 1'b0;
    int pwait = 0, npoll = 0, nwant = 0, want_idx = -1;
    int nb = 0, ntx = 0, t_off = 0, t_lastpoll = 0;
    logic [7:0] lb [256];
    int lt [256];
    logic [7:0] eb [256];
    int et [256];
    bit exp_prog = 1'b0;

    assign frame_data = 8'h30 + 8'(sidx);

    cfgseq #(.CLK_HZ(CLK_HZ), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .partial_req(partial_req),
        .payload_len(payload_len), .frame_data(frame_data),
        .frame_valid(frame_valid), .frame_ready(frame_ready),
        .spi_cs(spi_cs), .spi_req(spi_req), .spi_wdata(spi_wdata),
        .spi_ack(spi_ack), .spi_rdata(spi_rdata),
        .poll_req(poll_req), .poll_want_ready(poll_want_ready),
        .poll_done(poll_done), .poll_result(poll_result),
        .busy(busy), .done(done), .err_code(err_code), .prog_mode(prog_mode)
    );

    initial forever #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
        if (frame_valid && frame_ready) sidx <= sidx + 1;
    end

    // SPI byte responder and status poller
    initial forever begin
        @(negedge clk);
        spi_ack = 1'b0;
        poll_done = 1'b0;
        poll_result = 2'd0;
        frame_valid = stall ? ((cyc % 3) != 0) : 1'b1;
        #1;
        if (spi_cs && !prev_cs) ntx++;
        prev_cs = spi_cs;
        if (spi_req) begin
            spi_ack = 1'b1;
            spi_rdata = rd_val;
            lb[nb] = spi_wdata;
            lt[nb] = ntx;
            if (spi_wdata == 8'h0C) t_off = cyc;
            nb++;
        end
        if (poll_req) begin
            if (!in_poll) begin
                in_poll = 1'b1;
                pwait = 0;
                if (poll_want_ready) begin nwant++; want_idx = npoll; end
                t_lastpoll = cyc;
                npoll++;
            end
            pwait++;
            if (pwait == 2) begin
                poll_done = 1'b1;
                poll_result = (npoll - 1 == fail_at) ? fail_kind : 2'd0;
            end
        end else begin
            in_poll = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int len, input bit partial, input logic [7:0] rv,
                       input int fa, input logic [1:0] fk, input bit st,
                       input bit poke, input int exp_err);
        int frames, exp_tx, exp_polls, ne, nmatch, exp_nb, n;
        fail_at = fa; fail_kind = fk; rd_val = rv; stall = st;
        nb = 0; ntx = 0; npoll = 0; nwant = 0; want_idx = -1; t_off = 0;
        sidx = 0;
        frames = len / 16;
        @(negedge clk);
        start = 1'b1; partial_req = partial; payload_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0; partial_req = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            if (poke && n == 20) begin start = 1'b1; partial_req = 1'b1; end
            else begin start = 1'b0; partial_req = 1'b0; end
            @(negedge clk);
            n++;
        end
        start = 1'b0; partial_req = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R10 done pulse with busy low", int'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done is one cycle", int'(done), 0);
        repeat (2) @(negedge clk);

        if (exp_err == 0) begin exp_tx = 5 + frames; exp_polls = exp_tx; exp_prog = 1'b0; end
        else if (exp_err <= 2) begin exp_tx = 0; exp_polls = 0; end
        else if (exp_err == 3) begin exp_tx = 2; exp_polls = 2; end
        else begin exp_tx = fa; exp_polls = fa + 1; if (fa >= 3) exp_prog = 1'b1; end

        ne = 0;
        eb[ne] = 8'h0B; et[ne] = 1; ne++;
        eb[ne] = 8'h01; et[ne] = 2; ne++;
        for (int j = 0; j < 4; j++) begin eb[ne] = 8'h00; et[ne] = 2; ne++; end
        eb[ne] = 8'hAE; et[ne] = 3; ne++;
        eb[ne] = 8'h01; et[ne] = 3; ne++;
        for (int f = 0; f < frames; f++) begin
            eb[ne] = 8'hEE; et[ne] = 4 + f; ne++;
            for (int j = 0; j < 16; j++) begin
                eb[ne] = 8'h30 + 8'(f * 16 + j); et[ne] = 4 + f; ne++;
            end
        end
        eb[ne] = 8'h0C; et[ne] = 4 + frames; ne++;
        eb[ne] = 8'h23; et[ne] = 5 + frames; ne++;
        exp_nb = 0;
        for (int k = 0; k < ne; k++) if (et[k] <= exp_tx) exp_nb++;

        chk(int'(err_code) == exp_err, "R6/R8/R9/R2 error code", int'(err_code), exp_err);
        chk(ntx == exp_tx, "R1/R4/R6 transaction count", ntx, exp_tx);
        chk(nb == exp_nb, "R4 byte count", nb, exp_nb);
        nmatch = 0;
        for (int k = 0; k < exp_nb && k < nb; k++)
            if (lb[k] == eb[k] && lt[k] == et[k]) nmatch++;
        chk(nmatch == exp_nb, "R1/R2/R3/R4/R7 byte order and framing", nmatch, exp_nb);
        chk(npoll == exp_polls, "R5 one poll per transaction", npoll, exp_polls);
        chk(nwant == ((exp_polls >= 2) ? 1 : 0) && (exp_polls < 2 || want_idx == 1),
            "R5 ready wait only before read-back", want_idx, 1);
        chk(prog_mode === exp_prog, "R3/R10 programming-mode flag", int'(prog_mode), int'(exp_prog));
        if (exp_err == 0)
            chk(t_lastpoll - t_off == DLY + 2, "R7 release pause", t_lastpoll - t_off, DLY + 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !prog_mode && err_code == 3'd0 && !spi_cs && !poll_req,
            "reset state", int'(busy), 0);

        // main flow over frame counts, R1 R2 R3 R4 R5 R7
        for (int f = 0; f <= 4; f++) run(f * 16, 0, 8'h00, -1, 2'd0, 0, 0, 0);
        run(48, 0, 8'h00, -1, 2'd0, 1, 0, 0);   // R4 stalled stream
        run(64, 0, 8'h00, -1, 2'd0, 1, 0, 0);

        // R8 lengths that are not frame multiples
        for (int l = 1; l < 48; l++)
            if (l % 16 != 0) run(l, 0, 8'h00, -1, 2'd0, 0, 0, 1);

        // R9 partial requests, precedence over length
        run(32, 1, 8'h00, -1, 2'd0, 0, 0, 2);
        run(20, 1, 8'h00, -1, 2'd0, 0, 0, 2);

        // R2 read-back failures
        run(32, 0, 8'h01, -1, 2'd0, 0, 0, 3);
        run(16, 0, 8'h80, -1, 2'd0, 0, 0, 3);

        // R6 poll failure at every poll position, both causes
        for (int p = 0; p < 7; p++) begin
            run(32, 0, 8'h00, p, 2'd1, 0, 0, 4);
            run(32, 0, 8'h00, p, (p % 2 == 0) ? 2'd2 : 2'd3, 0, 0, 5);
        end

        // R10 error held while idle
        repeat (20) @(negedge clk);
        chk(err_code == 3'd5, "R10 error code held", int'(err_code), 5);

        // R11 start (with partial flag) while busy is ignored
        run(32, 0, 8'h00, -1, 2'd0, 0, 1, 0);

        // R10 next start clears a held error
        run(16, 0, 8'h00, 2, 2'd1, 0, 0, 4);
        run(16, 0, 8'h00, -1, 2'd0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule